// File: doc/BRIEF.md
# Machine Interrupt Take Arbiter

This block decides, once per clock, whether a pending interrupt should be taken and which cause wins. It receives the pending, enable and delegation vectors, the current privilege level and the two global interrupt-enable status bits. A non-delegated interrupt that is both pending and enabled targets machine mode. A delegated one targets supervisor mode. The winner is chosen by a fixed service ranking, not by bit index.

The result is registered. A take flag, the winning cause index and a flag marking a supervisor-mode target appear one cycle after the inputs that produced them. Two event strobes mark a return instruction and a write to any control register the decision depends on. When either strobe is sampled, the decision made from the old register contents is discarded. The next decision then comes from the updated state. The non-maskable interrupt has no bit in the pending vector and is not arbitrated here.

Top module: `irq_take_arbiter`

## Requirements
- R1: During and directly after reset, take_valid, take_cause and take_smode are all zero.
- R2: A cause targets machine mode only when its irq_pend and irq_en bits are 1 and its irq_deleg bit is 0. Only causes 1, 3, 5, 7, 9, 11, 13 and every index of 16 and above are arbitrated. All other bits below 16 are ignored.
- R3: A machine-targeted cause is taken when cur_priv is 2'b11 and m_glob_en is 1, or when cur_priv is any value other than 2'b11 (regardless of m_glob_en).
- R4: Among standard machine-targeted causes, the winner follows this ranking, highest first: 11, 3, 7, 9, 1, 5, 13.
- R5: Platform causes (index 16 and above) rank above all standard causes, and the lowest platform index wins among them.
- R6: A takeable machine-targeted cause always beats any supervisor-targeted cause, and then take_smode is 0.
- R7: A delegated pending and enabled cause is taken with take_smode 1 when cur_priv is 2'b00, or when cur_priv is 2'b01 and s_glob_en is 1. It is never taken when cur_priv is 2'b11 or 2'b10. The ranking of R4/R5 applies among supervisor-targeted causes.
- R8: When xret_strobe or csr_wr_strobe is 1 at a clock edge, take_valid is 0 after that edge. The next edge evaluates the inputs afresh.
- R9: When no cause qualifies, take_valid, take_cause and take_smode are all zero.
- R10: The outputs change only at a clock edge and reflect the inputs sampled at that edge, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | NCAUSE | Pending interrupt vector, bit i is cause i |
| irq_en | input | NCAUSE | Interrupt enable vector |
| irq_deleg | input | NCAUSE | Delegation mask, 1 sends the cause to supervisor mode |
| cur_priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| m_glob_en | input | 1 | Machine global interrupt enable status bit |
| s_glob_en | input | 1 | Supervisor global interrupt enable status bit |
| xret_strobe | input | 1 | Return instruction executed this cycle |
| csr_wr_strobe | input | 1 | Pending, enable, status or delegation register written this cycle |
| take_valid | output | 1 | An interrupt is to be taken |
| take_cause | output | $clog2(NCAUSE) | Winning cause index |
| take_smode | output | 1 | Winner targets supervisor mode |

## Verification
The hardest situation to reach is the full ranking walk. It needs all seven standard causes pending together, with each winner then withdrawn in turn while every other condition stays fixed. The stimulus holds privilege and enables steady and clears one pending bit per step, checking the winner each time. A second hard case mixes delegated and non-delegated causes under a lower privilege, so that the machine-over-supervisor precedence can be told apart from plain ranking. The strobe case checks that the decision is suppressed for exactly one cycle and then comes back.

// File: rtl/irq_take_arbiter.sv
module irq_take_arbiter #(
  parameter int unsigned NCAUSE = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCAUSE-1:0]         irq_pend,
  input  logic [NCAUSE-1:0]         irq_en,
  input  logic [NCAUSE-1:0]         irq_deleg,
  input  logic [1:0]                cur_priv,
  input  logic                      m_glob_en,
  input  logic                      s_glob_en,
  input  logic                      xret_strobe,
  input  logic                      csr_wr_strobe,
  output logic                      take_valid,
  output logic [$clog2(NCAUSE)-1:0] take_cause,
  output logic                      take_smode
);
  localparam int unsigned CW = $clog2(NCAUSE);
  localparam int unsigned PLAT_BASE = 16;
  localparam int unsigned NSTD = 7;
  localparam int unsigned RANK [NSTD] = '{11, 3, 7, 9, 1, 5, 13};

  function automatic logic [CW:0] pick(input logic [NCAUSE-1:0] v);
    logic [CW:0] r;
    r = '0;
    for (int k = NSTD - 1; k >= 0; k--)
      if (v[RANK[k]]) r = {1'b1, CW'(RANK[k])};
    for (int i = NCAUSE - 1; i >= PLAT_BASE; i--)
      if (v[i]) r = {1'b1, CW'(i)};
    return r;
  endfunction

  logic [NCAUSE-1:0] m_vec, s_vec;
  logic [CW:0]       m_sel, s_sel;
  logic              m_ok, s_ok, m_fire, s_fire, stale;

  assign m_vec  = irq_pend & irq_en & ~irq_deleg;
  assign s_vec  = irq_pend & irq_en & irq_deleg;
  assign m_sel  = pick(m_vec);
  assign s_sel  = pick(s_vec);
  assign m_ok   = (cur_priv == 2'b11) ? m_glob_en : 1'b1;
  assign s_ok   = (cur_priv == 2'b00) || ((cur_priv == 2'b01) && s_glob_en);
  assign m_fire = m_sel[CW] && m_ok;
  assign s_fire = s_sel[CW] && s_ok;
  assign stale  = xret_strobe || csr_wr_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n || stale) begin
      take_valid <= 1'b0;
      take_cause <= '0;
      take_smode <= 1'b0;
    end else if (m_fire) begin
      take_valid <= 1'b1;
      take_cause <= m_sel[CW-1:0];
      take_smode <= 1'b0;
    end else if (s_fire) begin
      take_valid <= 1'b1;
      take_cause <= s_sel[CW-1:0];
      take_smode <= 1'b1;
    end else begin
      take_valid <= 1'b0;
      take_cause <= '0;
      take_smode <= 1'b0;
    end
  end

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take_valid |-> (take_cause == '0) && !take_smode);

  p_strobe_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xret_strobe || csr_wr_strobe) |=> !take_valid);

  p_mmode_no_s_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv == 2'b11) |=> !take_smode);

  p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv == 2'b11 && !m_glob_en) |=> !take_valid);

  p_m_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !take_smode) |->
      ((($past(irq_pend & irq_en & ~irq_deleg)) >> take_cause) & NCAUSE'(1)) != '0);

  p_s_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_smode |->
      ((($past(irq_pend & irq_en & irq_deleg)) >> take_cause) & NCAUSE'(1)) != '0);
endmodule

// File: tb/irq_take_arbiter_bench.sv
module irq_take_arbiter_bench;
  localparam int unsigned N = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pend = '0, en = '0, dlg = '0;
  logic [1:0] priv = 2'b11;
  logic mge = 1'b0, sge = 1'b0, xret = 1'b0, cwr = 1'b0;
  logic tv, ts;
  logic [4:0] tc;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_take_arbiter #(.NCAUSE(N)) u_irq_take_arbiter (
    .clk(clk), .rst_n(rst_n), .irq_pend(pend), .irq_en(en), .irq_deleg(dlg),
    .cur_priv(priv), .m_glob_en(mge), .s_glob_en(sge),
    .xret_strobe(xret), .csr_wr_strobe(cwr),
    .take_valid(tv), .take_cause(tc), .take_smode(ts));

  task automatic chk(string req, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic expect_out(string req, int v, int c, int s);
    chk(req, tv, v, "take_valid");
    chk(req, tc, c, "take_cause");
    chk(req, ts, s, "take_smode");
  endtask

  task automatic setin(logic [N-1:0] p, logic [N-1:0] e, logic [N-1:0] d,
                       logic [1:0] pv, logic mg, logic sg);
    @(negedge clk);
    pend = p; en = e; dlg = d; priv = pv; mge = mg; sge = sg;
    @(negedge clk);
  endtask

  task automatic t_reset();
    pend = '1; en = '1; mge = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R1", 0, 0, 0);
    pend = '0; en = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1", 0, 0, 0);
  endtask

  task automatic t_qualify();
    setin(32'h80, 32'h80, 0, 2'b11, 1, 0);
    expect_out("R2", 1, 7, 0);
    setin(32'h80, 32'h00, 0, 2'b11, 1, 0);
    expect_out("R9", 0, 0, 0);
    setin(32'h0001_5555, 32'h0001_5555, 0, 2'b11, 1, 0);
    expect_out("R2", 1, 16, 0);
    setin(32'h0000_5555, 32'h0000_5555, 0, 2'b11, 1, 0);
    expect_out("R2", 0, 0, 0);
  endtask

  task automatic t_gate();
    setin(32'h80, 32'h80, 0, 2'b11, 0, 1);
    expect_out("R3", 0, 0, 0);
    setin(32'h80, 32'h80, 0, 2'b01, 0, 0);
    expect_out("R3", 1, 7, 0);
    setin(32'h80, 32'h80, 0, 2'b00, 0, 0);
    expect_out("R3", 1, 7, 0);
  endtask

  task automatic t_rank();
    int order [7] = '{11, 3, 7, 9, 1, 5, 13};
    logic [N-1:0] p = 32'h2AAA;
    for (int k = 0; k < 7; k++) begin
      setin(p, '1, 0, 2'b11, 1, 0);
      expect_out("R4", 1, order[k], 0);
      p[order[k]] = 1'b0;
    end
    setin(p, '1, 0, 2'b11, 1, 0);
    expect_out("R9", 0, 0, 0);
  endtask

  task automatic t_platform();
    setin(32'h0012_0800, '1, 0, 2'b11, 1, 0);
    expect_out("R5", 1, 17, 0);
    setin(32'h8000_0800, '1, 0, 2'b11, 1, 0);
    expect_out("R5", 1, 31, 0);
  endtask

  task automatic t_m_over_s();
    setin(32'h0820, '1, 32'h0800, 2'b00, 0, 1);
    expect_out("R6", 1, 5, 0);
    setin(32'h0820, '1, 32'h0800, 2'b11, 0, 1);
    expect_out("R6", 0, 0, 0);
  endtask

  task automatic t_smode();
    setin(32'h0220, '1, 32'h0220, 2'b00, 0, 0);
    expect_out("R7", 1, 9, 1);
    setin(32'h0220, '1, 32'h0220, 2'b01, 0, 0);
    expect_out("R7", 0, 0, 0);
    setin(32'h0220, '1, 32'h0220, 2'b01, 0, 1);
    expect_out("R7", 1, 9, 1);
    setin(32'h0220, '1, 32'h0220, 2'b11, 1, 1);
    expect_out("R7", 0, 0, 0);
    setin(32'h0220, '1, 32'h0220, 2'b10, 0, 1);
    expect_out("R7", 0, 0, 0);
  endtask

  task automatic t_strobe();
    setin(32'h0008, '1, 0, 2'b11, 1, 0);
    expect_out("R8", 1, 3, 0);
    cwr = 1'b1;
    @(negedge clk);
    cwr = 1'b0;
    expect_out("R8", 0, 0, 0);
    @(negedge clk);
    expect_out("R8", 1, 3, 0);
    xret = 1'b1;
    @(negedge clk);
    xret = 1'b0;
    expect_out("R8", 0, 0, 0);
    @(negedge clk);
    expect_out("R8", 1, 3, 0);
  endtask

  task automatic t_latency();
    setin(32'h2000, '1, 0, 2'b11, 1, 0);
    expect_out("R10", 1, 13, 0);
    @(negedge clk);
    pend = 32'h0080;
    #1;
    chk("R10", tc, 13, "take_cause before edge");
    @(negedge clk);
    chk("R10", tc, 7, "take_cause after edge");
  endtask

  initial begin
    t_reset();
    t_qualify();
    t_gate();
    t_rank();
    t_platform();
    t_m_over_s();
    t_smode();
    t_strobe();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule